// File: doc/BRIEF.md
# Asynchronous Handshake Bus Master

This block turns single transfer requests from an on-chip client into handshaked cycles on an external 16-bit bus. The client presents a byte address, a byte or word size, a direction and an address space. The block then runs one bus cycle. It drives the address space as a 3-bit function code, the word address, an address strobe, an upper and a lower byte strobe, and a read/write line. It keeps the cycle open until the addressed slave pulls its active-low acknowledge line low. It then closes the cycle and returns one response to the client.

A cycle runs through eight fixed phases, S0 to S7, at one clock each. Only the acknowledge wait in S4 stretches the cycle. The acknowledge input passes through a two-stage synchronizer before the sequencer sees it. The byte-address bit 0 never leaves the block. It only chooses which byte strobe is used and which data lane is used. If a word request has an odd address, or the address-space code is unknown, the request is refused with an error response and no bus cycle is run.

Top module: `hs_bus_master`

## Requirements
- R1: While reset is asserted and after it is released: address strobe, both byte strobes and read/write are high, the output enable is low, the function code is 000, req_ready is 1 and resp_valid is 0.
- R2: The function code is set from req_space as follows: 0 gives 001, 1 gives 010, 2 gives 101, 3 gives 110 and 4 gives 111. This code is held for as long as the address strobe is low.
- R3: A req_space value of 5, 6 or 7 is refused. In the cycle after acceptance, resp_valid and resp_err are both 1, and the address strobe stays high throughout.
- R4: A word request (req_word=1) with req_addr[0]=1 is refused in the same way as R3, and no bus cycle is run.
- R5: For a byte access, req_addr[0]=0 lowers only the upper strobe (lane D15..D8), and req_addr[0]=1 lowers only the lower strobe (lane D7..D0). A word access lowers both strobes. bus_addr carries req_addr[23:1].
- R6: Counting the first cycle after acceptance as cycle 1: the address, function code and read/write are valid from cycle 1, and the address strobe goes low in cycle 3. For a read, the byte strobes also go low in cycle 3.
- R7: For a write, the output enable rises in cycle 4 and the byte strobes go low in cycle 5, so the data is on the bus one cycle before any strobe.
- R8: If the slave lowers the acknowledge line k cycles after it first sees the address strobe low, the address strobe stays low for exactly 5+k cycles.
- R9: A read response comes in the cycle in which the address strobe rises again, with resp_err=0. A word read returns the whole bus. A byte read returns the selected lane in bits 7..0, with bits 15..8 set to zero.
- R10: A word write drives req_wdata. A byte write drives req_wdata[7:0] on both lanes.
- R11: Read/write is low for every cycle of a write in which the address strobe is low, and it is high during a read.
- R12: After a cycle ends, req_ready stays 0 and the address strobe stays high while the acknowledge line is held low. A new request is accepted only after the acknowledge line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address; bit 0 stays internal |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Address space code (see R2) |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Request refused (R3, R4) |
| resp_rdata | output | DATA_W | Read data |
| bus_fc | output | 3 | Function code |
| bus_addr | output | ADDR_W-1 | Word address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper byte strobe, active low |
| bus_lds_n | output | 1 | Lower byte strobe, active low |
| bus_rw_n | output | 1 | High = read, low = write |
| bus_dtack_n | input | 1 | Slave acknowledge, active low |
| bus_din | input | DATA_W | Data from the slave |
| bus_dout | output | DATA_W | Data to the slave |
| bus_dout_oe | output | 1 | Enable for bus_dout |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one or two clocks. It moves the edge of the address strobe or a byte strobe away from cycle 3 or 5, or it changes the strobe-low count from 5+k. A wrong latched size or A0 shows up on the first strobe as the wrong lane. It shows up again in the response as a shifted or unmasked read byte. A missed acknowledge recovery is seen as req_ready rising, or the strobe falling, while the acknowledge line is still held low after the cycle.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_S0, PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_S6, PH_S7,
        PH_HOLD,
        PH_REJ
    } phase_t;

    typedef struct packed {
        logic       word;
        logic       write;
        logic       a0;
        logic [2:0] fc;
    } xfer_t;

    localparam logic [2:0] FC_NONE  = 3'b000;
    localparam logic [2:0] FC_UDATA = 3'b001;
    localparam logic [2:0] FC_UPROG = 3'b010;
    localparam logic [2:0] FC_SDATA = 3'b101;
    localparam logic [2:0] FC_SPROG = 3'b110;
    localparam logic [2:0] FC_IACK  = 3'b111;

    function automatic logic space_legal(input logic [2:0] sp);
        return sp <= 3'd4;
    endfunction

    function automatic logic [2:0] space_to_fc(input logic [2:0] sp);
        case (sp)
            3'd0:    return FC_UDATA;
            3'd1:    return FC_UPROG;
            3'd2:    return FC_SDATA;
            3'd3:    return FC_SPROG;
            3'd4:    return FC_IACK;
            default: return FC_NONE;
        endcase
    endfunction

    function automatic logic fc_legal(input logic [2:0] fc);
        return (fc == FC_UDATA) || (fc == FC_UPROG) || (fc == FC_SDATA) ||
               (fc == FC_SPROG) || (fc == FC_IACK);
    endfunction

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_n};
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];
endmodule

// File: rtl/hsbus_seq.sv
module hsbus_seq
    import hsbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_legal,
    input  logic   ack_low,
    output phase_t phase,
    output logic   req_ready
);
    phase_t nxt;

    assign req_ready = (phase == PH_IDLE);

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (req_valid) nxt = req_legal ? PH_S0 : PH_REJ;
            PH_S0:   nxt = PH_S1;
            PH_S1:   nxt = PH_S2;
            PH_S2:   nxt = PH_S3;
            PH_S3:   nxt = PH_S4;
            PH_S4:   if (ack_low) nxt = PH_S5;
            PH_S5:   nxt = PH_S6;
            PH_S6:   nxt = PH_S7;
            PH_S7:   nxt = ack_low ? PH_HOLD : PH_IDLE;
            PH_HOLD: if (!ack_low) nxt = PH_IDLE;
            PH_REJ:  nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/hsbus_lanes.sv
module hsbus_lanes
    import hsbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  phase_t            phase,
    input  xfer_t             cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic              as_n,
    output logic              uds_n,
    output logic              lds_n,
    output logic              rw_n,
    output logic              oe,
    output logic [2:0]        fc,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rd_lane
);
    localparam int LANE_W = DATA_W / 2;

    logic in_cycle, as_on, strobe_on;

    always_comb begin
        in_cycle  = (phase >= PH_S0) && (phase <= PH_S7);
        as_on     = (phase >= PH_S2) && (phase <= PH_S6);
        strobe_on = cur.write ? ((phase >= PH_S4) && (phase <= PH_S6)) : as_on;

        as_n  = !as_on;
        uds_n = !(strobe_on && (cur.word || !cur.a0));
        lds_n = !(strobe_on && (cur.word ||  cur.a0));
        rw_n  = !(cur.write && in_cycle);
        oe    = cur.write && (phase >= PH_S3) && (phase <= PH_S7);
        fc    = in_cycle ? cur.fc : FC_NONE;

        dout = cur.word ? wdata : {2{wdata[LANE_W-1:0]}};

        if (cur.word)
            rd_lane = din;
        else if (cur.a0)
            rd_lane = {{LANE_W{1'b0}}, din[LANE_W-1:0]};
        else
            rd_lane = {{LANE_W{1'b0}}, din[DATA_W-1:LANE_W]};
    end
endmodule

// File: rtl/hs_bus_master.sv
module hs_bus_master
    import hsbus_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [2:0]        req_space,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [2:0]        bus_fc,
    output logic [ADDR_W-2:0] bus_addr,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw_n,
    input  logic              bus_dtack_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_oe
);
    localparam int WADDR_W = ADDR_W - 1;

    phase_t              phase;
    xfer_t               cur;
    logic [WADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q, lane_rd;
    logic                dtack_q_n, ack_low, req_legal, take;

    assign req_legal = space_legal(req_space) && !(req_word && req_addr[0]);
    assign take      = req_valid && req_ready;
    assign ack_low   = !dtack_q_n;

    hsbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (bus_dtack_n),
        .q_n (dtack_q_n)
    );

    hsbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_legal (req_legal),
        .ack_low   (ack_low),
        .phase     (phase),
        .req_ready (req_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (take) begin
                cur     <= '{word: req_word, write: req_write,
                             a0: req_addr[0], fc: space_to_fc(req_space)};
                addr_q  <= req_addr[ADDR_W-1:1];
                wdata_q <= req_wdata;
                rdata_q <= '0;
            end else if (phase == PH_S6 && !cur.write) begin
                rdata_q <= lane_rd;
            end
        end
    end

    hsbus_lanes #(.DATA_W(DATA_W)) u_lanes (
        .phase   (phase),
        .cur     (cur),
        .wdata   (wdata_q),
        .din     (bus_din),
        .as_n    (bus_as_n),
        .uds_n   (bus_uds_n),
        .lds_n   (bus_lds_n),
        .rw_n    (bus_rw_n),
        .oe      (bus_dout_oe),
        .fc      (bus_fc),
        .dout    (bus_dout),
        .rd_lane (lane_rd)
    );

    assign bus_addr   = addr_q;
    assign resp_valid = (phase == PH_S7) || (phase == PH_REJ);
    assign resp_err   = (phase == PH_REJ);
    assign resp_rdata = rdata_q;
endmodule

// File: rtl/hsbus_chk.sv
module hsbus_chk
    import hsbus_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       resp_valid,
    input logic       resp_err,
    input logic [2:0] bus_fc,
    input logic       bus_as_n,
    input logic       bus_uds_n,
    input logic       bus_lds_n,
    input logic       bus_rw_n,
    input logic       bus_dout_oe
);
    // R2: a legal function code whenever the address strobe is low
    assert_fc_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> fc_legal(bus_fc));

    // R5: byte strobes only inside an address strobe
    assert_strobe_in_as_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    // R7: write data is driven at least one cycle before a strobe
    assert_wr_data_first_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus_rw_n && (!bus_uds_n || !bus_lds_n)) |-> (bus_dout_oe && $past(bus_dout_oe)));

    // R11: read/write does not change during an address strobe
    assert_rw_steady_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |=> (bus_as_n || $stable(bus_rw_n)));

    // R3: an error response never comes with a bus cycle
    assert_err_resp_R3: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && bus_as_n));

    // R9: a good response comes when the address strobe rises
    assert_resp_after_as_R9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_err) |-> $rose(bus_as_n));

    // R12: when ready, the bus is quiet
    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_as_n && bus_uds_n && bus_lds_n));
endmodule

bind hs_bus_master hsbus_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err),
    .bus_fc      (bus_fc),
    .bus_as_n    (bus_as_n),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_rw_n    (bus_rw_n),
    .bus_dout_oe (bus_dout_oe)
);

// File: tb/sim_hs_bus_master.sv
`timescale 1ns/1ps
module sim_hs_bus_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_space = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid, resp_err;
    logic [15:0] resp_rdata;
    logic [2:0]  bus_fc;
    logic [22:0] bus_addr;
    logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_dout_oe;
    logic        bus_dtack_n = 1'b1;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;

    int checks = 0;
    int errors = 0;

    // per-transfer observations
    int          r_first_as, r_first_strb, r_first_oe, r_as_cnt, r_resp_idx;
    logic        r_err, r_uds, r_lds, r_oe_at_strb, r_rw_bad, r_hold_bad, r_done;
    logic [15:0] r_rdata, r_dout;
    logic [2:0]  r_fc;
    logic [22:0] r_addr;

    always #10 clk = ~clk;

    hs_bus_master u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_space(req_space),
        .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw_n(bus_rw_n),
        .bus_dtack_n(bus_dtack_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_dout_oe(bus_dout_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One transfer, with the bench acting as the slave.
    task automatic do_xfer(input logic [23:0] a, input logic w, input logic wr,
                           input logic [2:0] sp, input logic [15:0] wd,
                           input logic [15:0] sd, input int waits, input int hold);
        int n;
        int hold_left;
        n = 0; hold_left = hold;
        r_first_as = 0; r_first_strb = 0; r_first_oe = 0; r_as_cnt = 0; r_resp_idx = 0;
        r_err = 0; r_uds = 1; r_lds = 1; r_oe_at_strb = 0; r_rw_bad = 0; r_hold_bad = 0;
        r_done = 0; r_rdata = '0; r_dout = '0; r_fc = '0; r_addr = '0;
        @(negedge clk);
        req_addr = a; req_word = w; req_write = wr; req_space = sp; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        while (!r_done && n < 100) begin
            n++;
            if (n == 1) req_valid = 1'b0;
            if (!bus_as_n) begin
                if (r_as_cnt == 0) begin
                    r_first_as = n; r_fc = bus_fc; r_addr = bus_addr;
                end
                r_as_cnt++;
                if (bus_rw_n !== !wr) r_rw_bad = 1;
                if (r_as_cnt >= waits + 1) begin
                    bus_dtack_n = 1'b0; bus_din = sd;
                end
            end else if (r_as_cnt > 0) begin
                if (hold_left > 0) begin
                    hold_left--;
                    if (req_ready) r_hold_bad = 1;
                end else begin
                    bus_dtack_n = 1'b1;
                end
            end
            if ((!bus_uds_n || !bus_lds_n) && r_first_strb == 0) begin
                r_first_strb = n; r_uds = bus_uds_n; r_lds = bus_lds_n;
                r_dout = bus_dout; r_oe_at_strb = bus_dout_oe;
            end
            if (bus_dout_oe && r_first_oe == 0) r_first_oe = n;
            if (resp_valid) begin
                r_resp_idx = n; r_err = resp_err; r_rdata = resp_rdata;
            end
            if (r_resp_idx != 0 && req_ready) r_done = 1;
            if (!r_done) @(negedge clk);
        end
        bus_dtack_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 as_n",  bus_as_n, 1);
        chk("R1 uds_n", bus_uds_n, 1);
        chk("R1 lds_n", bus_lds_n, 1);
        chk("R1 rw_n",  bus_rw_n, 1);
        chk("R1 oe",    bus_dout_oe, 0);
        chk("R1 fc",    bus_fc, 0);
        chk("R1 ready", req_ready, 1);
        chk("R1 resp",  resp_valid, 0);
    endtask

    task automatic t_read_even();
        do_xfer(24'h001234, 0, 0, 3'd0, 16'h0, 16'hA55A, 0, 0);
        chk("R2 fc user data", r_fc, 3'b001);
        chk("R5 addr", r_addr, 23'h00091A);
        chk("R6 as fall cycle", r_first_as, 3);
        chk("R6 read strobe cycle", r_first_strb, 3);
        chk("R5 even uds", r_uds, 0);
        chk("R5 even lds", r_lds, 1);
        chk("R8 as len k=0", r_as_cnt, 5);
        chk("R9 resp cycle", r_resp_idx, 8);
        chk("R9 even rdata", r_rdata, 16'h00A5);
        chk("R9 err", r_err, 0);
        chk("R11 rw read", r_rw_bad, 0);
    endtask

    task automatic t_read_odd();
        do_xfer(24'h0ABCD5, 0, 0, 3'd2, 16'h0, 16'h3C96, 3, 0);
        chk("R2 fc super data", r_fc, 3'b101);
        chk("R5 odd uds", r_uds, 1);
        chk("R5 odd lds", r_lds, 0);
        chk("R8 as len k=3", r_as_cnt, 8);
        chk("R9 resp cycle k=3", r_resp_idx, 11);
        chk("R9 odd rdata", r_rdata, 16'h0096);
    endtask

    task automatic t_read_word();
        do_xfer(24'h7FFFFE, 1, 0, 3'd3, 16'h0, 16'hBEEF, 1, 0);
        chk("R2 fc super prog", r_fc, 3'b110);
        chk("R5 word uds", r_uds, 0);
        chk("R5 word lds", r_lds, 0);
        chk("R5 word addr", r_addr, 23'h3FFFFF);
        chk("R8 as len k=1", r_as_cnt, 6);
        chk("R9 word rdata", r_rdata, 16'hBEEF);
    endtask

    task automatic t_iack();
        do_xfer(24'hFFFFF0, 1, 0, 3'd4, 16'h0, 16'h0042, 2, 0);
        chk("R2 fc iack", r_fc, 3'b111);
        chk("R8 as len k=2", r_as_cnt, 7);
        chk("R9 iack rdata", r_rdata, 16'h0042);
    endtask

    task automatic t_write_word();
        do_xfer(24'h000100, 1, 1, 3'd1, 16'h1357, 16'hFFFF, 0, 0);
        chk("R2 fc user prog", r_fc, 3'b010);
        chk("R6 wr as fall", r_first_as, 3);
        chk("R7 oe cycle", r_first_oe, 4);
        chk("R7 strobe cycle", r_first_strb, 5);
        chk("R7 oe at strobe", r_oe_at_strb, 1);
        chk("R10 word dout", r_dout, 16'h1357);
        chk("R11 rw write", r_rw_bad, 0);
        chk("R8 wr as len", r_as_cnt, 5);
        chk("R9 wr resp cycle", r_resp_idx, 8);
        chk("R9 wr err", r_err, 0);
    endtask

    task automatic t_write_byte();
        do_xfer(24'h000101, 0, 1, 3'd0, 16'h77C4, 16'h0, 2, 0);
        chk("R10 byte dout", r_dout, 16'hC4C4);
        chk("R5 wr odd uds", r_uds, 1);
        chk("R5 wr odd lds", r_lds, 0);
        chk("R7 byte strobe cycle", r_first_strb, 5);
        chk("R8 wr as len k=2", r_as_cnt, 7);
        chk("R11 rw byte write", r_rw_bad, 0);
    endtask

    task automatic t_rej_align();
        do_xfer(24'h000003, 1, 0, 3'd0, 16'h0, 16'h0, 0, 0);
        chk("R4 resp cycle", r_resp_idx, 1);
        chk("R4 err", r_err, 1);
        chk("R4 no bus", r_first_as, 0);
        chk("R4 no strobe", r_first_strb, 0);
    endtask

    task automatic t_rej_space();
        do_xfer(24'h000010, 0, 1, 3'd6, 16'h1111, 16'h0, 0, 0);
        chk("R3 resp cycle", r_resp_idx, 1);
        chk("R3 err", r_err, 1);
        chk("R3 no bus", r_first_as, 0);
        chk("R3 no oe", r_first_oe, 0);
    endtask

    task automatic t_hold();
        do_xfer(24'h000200, 0, 0, 3'd0, 16'h0, 16'h5A00, 0, 4);
        chk("R12 ready held low", r_hold_bad, 0);
        chk("R12 cycle ended", r_done, 1);
        chk("R12 as len", r_as_cnt, 5);
        chk("R12 rdata", r_rdata, 16'h005A);
        @(negedge clk);
        chk("R12 ready after release", req_ready, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_even();
        t_read_odd();
        t_read_word();
        t_iack();
        t_write_word();
        t_write_byte();
        t_rej_align();
        t_rej_space();
        t_read_even();
        t_hold();
        summary();
        $finish;
    end
endmodule